// File: doc/BRIEF.md
# Vector Lane Shuffle and Accumulator Clamp Stage

This stage sits between a vector register file and the writeback port of an
eight-lane, 16-bit SIMD unit. It has two jobs. The first is to reorder the
second source operand before it enters the arithmetic: a 4-bit element code
chooses, for every destination lane, which source lane it copies. The choices
are a straight copy, a duplicate of the even or odd lane of each pair, a
broadcast of one lane inside each half, or a broadcast of one lane to the full
vector.

The second job comes after a multiply-accumulate. Each lane holds a 48-bit
accumulator, and the stage narrows it to a signed 16-bit result. If the
accumulator does not fit, the lane returns one of two clamp constants that the
caller supplies. If it fits, the lane returns either its low or its middle
16-bit slice, as the slice select asks.

Both outputs are registered. All eight lanes of the result are written together
in the cycle after an input strobe, and the outputs hold their value while no
strobe arrives.

Top module: `vlane_shuffle_clamp`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `shuf_q` and `res_q` become zero on that edge.
- R2: Element codes 0 and 1 copy each lane straight through: destination lane i takes source lane i. Lane i occupies bits [16i+15:16i].
- R3: Element code 2 takes source lanes 0,0,2,2,4,4,6,6 for destination lanes 0..7. Code 3 takes 1,1,3,3,5,5,7,7.
- R4: For element codes 4 to 7, let k = code-4. Destination lanes 0..3 take source lane k and lanes 4..7 take source lane k+4.
- R5: For element codes 8 to 15, every destination lane takes source lane code-8.
- R6: The accumulator of lane i is `acc[48i+47:48i]`, with the high slice in bits 47:32, the middle in 31:16 and the low in 15:0. A lane whose high slice has its sign bit set and is not 0xFFFF returns `clamp_neg`.
- R7: A lane whose high slice equals 0xFFFF and whose middle slice has bit 15 clear returns `clamp_neg`.
- R8: A lane returns `clamp_pos` if its high slice has bit 15 clear and is nonzero, or if it is zero and the middle slice has bit 15 set.
- R9: A lane that meets none of the clamp conditions returns its low slice when `slice_mid` is 0 and its middle slice when `slice_mid` is 1.
- R10: `out_valid` is high in the cycle after an accepted `in_valid`. In that same cycle all eight lanes of `shuf_q` and `res_q` show the values computed from the inputs that came with the strobe. Each lane is computed independently of the others.
- R11: When `in_valid` is low, `shuf_q` and `res_q` keep their previous values whatever the other inputs do, and `out_valid` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe; loads the output registers |
| opnd_b | input | 128 | Second operand, eight 16-bit lanes |
| elem_sel | input | 4 | Element code for the lane shuffle |
| acc | input | 384 | Eight 48-bit lane accumulators |
| slice_mid | input | 1 | 0 returns the low slice, 1 returns the middle slice |
| clamp_neg | input | 16 | Value returned on negative overflow |
| clamp_pos | input | 16 | Value returned on positive overflow |
| shuf_q | output | 128 | Registered shuffled operand |
| res_q | output | 128 | Registered clamped result, all lanes |
| out_valid | output | 1 | High for one cycle after an accepted strobe |

## Verification
The stage holds no state beyond its output registers. A fault therefore shows up
at the ports in the cycle after the strobe that exposes it. A wrong entry in the
lane source map moves one source lane into the wrong destination lane of
`shuf_q`, and the bench can see this only because every source lane carries a
distinct value. A fault in a clamp decision shows as the wrong constant, or as a
raw slice where a constant belongs. The bench therefore puts accumulators on
both sides of every boundary of the high and middle slices, and in a single
strobe it gives different lanes different cases.

// File: rtl/vlane_pkg.sv
package vlane_pkg;
  localparam int LANES   = 8;
  localparam int LANE_W  = 16;
  localparam int ACC_W   = 48;
  localparam int SEL_W   = 4;
  localparam int IDX_W   = $clog2(LANES);
  localparam int VEC_W   = LANES * LANE_W;
  localparam int ACCV_W  = LANES * ACC_W;

  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_NEG  = 2'd1,
    SAT_POS  = 2'd2
  } sat_kind_e;
endpackage

// File: rtl/vlane_src_map.sv
module vlane_src_map #(
  parameter int LANES = vlane_pkg::LANES,
  parameter int SEL_W = vlane_pkg::SEL_W,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [SEL_W-1:0]       elem_sel,
  output logic [LANES*IDX_W-1:0] src_idx
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [IDX_W-1:0] LI = IDX_W'(g);
    logic [IDX_W-1:0] pick;
    always_comb begin
      if (elem_sel[SEL_W-1]) begin
        pick = elem_sel[IDX_W-1:0];
      end else if (elem_sel[SEL_W-2]) begin
        pick = {LI[IDX_W-1], elem_sel[IDX_W-2:0]};
      end else if (elem_sel[SEL_W-3]) begin
        pick = {LI[IDX_W-1:1], elem_sel[0]};
      end else begin
        pick = LI;
      end
    end
    assign src_idx[g*IDX_W +: IDX_W] = pick;
  end
endmodule

// File: rtl/vlane_xbar.sv
module vlane_xbar #(
  parameter int LANES  = vlane_pkg::LANES,
  parameter int LANE_W = vlane_pkg::LANE_W,
  localparam int IDX_W = $clog2(LANES),
  localparam int VEC_W = LANES * LANE_W
) (
  input  logic [VEC_W-1:0]       vec_in,
  input  logic [LANES*IDX_W-1:0] src_idx,
  output logic [VEC_W-1:0]       vec_out
);
  logic [LANE_W-1:0] lanes [LANES];

  for (genvar s = 0; s < LANES; s++) begin : g_unpack
    assign lanes[s] = vec_in[s*LANE_W +: LANE_W];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_dst
    assign vec_out[g*LANE_W +: LANE_W] = lanes[src_idx[g*IDX_W +: IDX_W]];
  end
endmodule

// File: rtl/vlane_sat.sv
module vlane_sat
  import vlane_pkg::*;
#(
  parameter int LANE_W = vlane_pkg::LANE_W,
  parameter int ACC_W  = vlane_pkg::ACC_W
) (
  input  logic [ACC_W-1:0]  acc_lane,
  input  logic              slice_mid,
  input  logic [LANE_W-1:0] clamp_neg,
  input  logic [LANE_W-1:0] clamp_pos,
  output logic [LANE_W-1:0] lane_out
);
  logic [LANE_W-1:0] hi, mid, lo;
  sat_kind_e         kind;

  assign hi  = acc_lane[3*LANE_W-1:2*LANE_W];
  assign mid = acc_lane[2*LANE_W-1:LANE_W];
  assign lo  = acc_lane[LANE_W-1:0];

  always_comb begin
    kind = SAT_NONE;
    if (hi[LANE_W-1]) begin
      if (hi != '1 || !mid[LANE_W-1]) kind = SAT_NEG;
    end else begin
      if (hi != '0 || mid[LANE_W-1]) kind = SAT_POS;
    end
  end

  always_comb begin
    unique case (kind)
      SAT_NEG: lane_out = clamp_neg;
      SAT_POS: lane_out = clamp_pos;
      default: lane_out = slice_mid ? mid : lo;
    endcase
  end
endmodule

// File: rtl/vlane_shuffle_clamp.sv
module vlane_shuffle_clamp #(
  parameter int LANES  = vlane_pkg::LANES,
  parameter int LANE_W = vlane_pkg::LANE_W,
  parameter int ACC_W  = vlane_pkg::ACC_W,
  parameter int SEL_W  = vlane_pkg::SEL_W,
  localparam int IDX_W  = $clog2(LANES),
  localparam int VEC_W  = LANES * LANE_W,
  localparam int ACCV_W = LANES * ACC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  opnd_b,
  input  logic [SEL_W-1:0]  elem_sel,
  input  logic [ACCV_W-1:0] acc,
  input  logic              slice_mid,
  input  logic [LANE_W-1:0] clamp_neg,
  input  logic [LANE_W-1:0] clamp_pos,
  output logic [VEC_W-1:0]  shuf_q,
  output logic [VEC_W-1:0]  res_q,
  output logic              out_valid
);
  logic [LANES*IDX_W-1:0] src_idx;
  logic [VEC_W-1:0]       shuf_d;
  logic [VEC_W-1:0]       res_d;

  vlane_src_map #(.LANES(LANES), .SEL_W(SEL_W)) u_map (
    .elem_sel (elem_sel),
    .src_idx  (src_idx)
  );

  vlane_xbar #(.LANES(LANES), .LANE_W(LANE_W)) u_xbar (
    .vec_in  (opnd_b),
    .src_idx (src_idx),
    .vec_out (shuf_d)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_sat
    vlane_sat #(.LANE_W(LANE_W), .ACC_W(ACC_W)) u_sat (
      .acc_lane  (acc[g*ACC_W +: ACC_W]),
      .slice_mid (slice_mid),
      .clamp_neg (clamp_neg),
      .clamp_pos (clamp_pos),
      .lane_out  (res_d[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shuf_q    <= '0;
      res_q     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        shuf_q <= shuf_d;
        res_q  <= res_d;
      end
    end
  end
endmodule

// File: rtl/vlane_shuffle_clamp_chk.sv
module vlane_shuffle_clamp_chk #(
  parameter int LANES  = 8,
  parameter int LANE_W = 16,
  parameter int ACC_W  = 48,
  parameter int SEL_W  = 4,
  localparam int VEC_W = LANES * LANE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [SEL_W-1:0]  elem_sel,
  input logic [ACC_W-1:0]  acc_lane0,
  input logic              slice_mid,
  input logic [LANE_W-1:0] clamp_neg,
  input logic [LANE_W-1:0] clamp_pos,
  input logic [VEC_W-1:0]  shuf_q,
  input logic [VEC_W-1:0]  res_q,
  input logic              out_valid
);
  logic [LANE_W-1:0] hi0, mid0, lo0;
  logic              all_same;
  assign hi0  = acc_lane0[3*LANE_W-1:2*LANE_W];
  assign mid0 = acc_lane0[2*LANE_W-1:LANE_W];
  assign lo0  = acc_lane0[LANE_W-1:0];

  always_comb begin
    all_same = 1'b1;
    for (int i = 1; i < LANES; i++)
      if (shuf_q[i*LANE_W +: LANE_W] != shuf_q[LANE_W-1:0]) all_same = 1'b0;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && res_q == '0 && shuf_q == '0)); // R1

  AST_FULL_BCAST: assert property (@(posedge clk) disable iff (rst)
    (in_valid && elem_sel[SEL_W-1]) |=> all_same); // R5

  AST_NEG_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hi0[LANE_W-1] && hi0 != '1) |=> res_q[LANE_W-1:0] == $past(clamp_neg)); // R6

  AST_NEG_EDGE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hi0 == '1 && !mid0[LANE_W-1]) |=> res_q[LANE_W-1:0] == $past(clamp_neg)); // R7

  AST_POS_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !hi0[LANE_W-1] && (hi0 != '0 || mid0[LANE_W-1])) |=> res_q[LANE_W-1:0] == $past(clamp_pos)); // R8

  AST_LOW_SLICE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hi0 == '0 && !mid0[LANE_W-1] && !slice_mid) |=> res_q[LANE_W-1:0] == $past(lo0)); // R9

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(res_q) && $stable(shuf_q))); // R11
endmodule

bind vlane_shuffle_clamp vlane_shuffle_clamp_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .ACC_W(ACC_W), .SEL_W(SEL_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .elem_sel  (elem_sel),
  .acc_lane0 (acc[ACC_W-1:0]),
  .slice_mid (slice_mid),
  .clamp_neg (clamp_neg),
  .clamp_pos (clamp_pos),
  .shuf_q    (shuf_q),
  .res_q     (res_q),
  .out_valid (out_valid)
);

// File: tb/vlane_shuffle_clamp_bench.sv
module vlane_shuffle_clamp_bench;
  localparam int LANES = 8;
  localparam int LW    = 16;
  localparam int AW    = 48;
  localparam int NROW  = 10;
  localparam int ROW_W = AW + 1 + LW;

  // {accumulator, slice_mid, expected lane result}; clamps: neg 8000, pos 7FFF
  localparam logic [ROW_W-1:0] CLAMP_TAB [NROW] = '{
    {48'h8000_1234_5678, 1'b0, 16'h8000},  // R6 large negative
    {48'hFFFE_FFFF_FFFF, 1'b1, 16'h8000},  // R6 just below FFFF
    {48'hFFFF_7FFF_0000, 1'b0, 16'h8000},  // R7 middle sign clear
    {48'hFFFF_8000_0001, 1'b0, 16'h0001},  // R9 negative in range, low
    {48'hFFFF_8000_0001, 1'b1, 16'h8000},  // R9 negative in range, middle
    {48'h0001_0000_0000, 1'b0, 16'h7FFF},  // R8 small positive high
    {48'h0000_8000_1111, 1'b1, 16'h7FFF},  // R8 middle sign set
    {48'h7FFF_FFFF_FFFF, 1'b0, 16'h7FFF},  // R8 largest positive
    {48'h0000_7FFF_ABCD, 1'b0, 16'hABCD},  // R9 positive in range, low
    {48'h0000_7FFF_ABCD, 1'b1, 16'h7FFF}   // R9 positive in range, middle
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [127:0]     opnd_b = '0;
  logic [3:0]       elem_sel = '0;
  logic [383:0]     acc = '0;
  logic             slice_mid = 1'b0;
  logic [15:0]      clamp_neg = 16'h8000;
  logic [15:0]      clamp_pos = 16'h7FFF;
  logic [127:0]     shuf_q, res_q;
  logic             out_valid;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  vlane_shuffle_clamp u_vlane_shuffle_clamp (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opnd_b(opnd_b),
    .elem_sel(elem_sel), .acc(acc), .slice_mid(slice_mid),
    .clamp_neg(clamp_neg), .clamp_pos(clamp_pos),
    .shuf_q(shuf_q), .res_q(res_q), .out_valid(out_valid)
  );

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int src_of(int code, int lane);
    if (code >= 8) return code - 8;
    if (code >= 4) return (lane < 4) ? code - 4 : code;
    if (code >= 2) return (lane & 6) + (code - 2);
    return lane;
  endfunction

  task automatic strobe();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [127:0] exp_v;
    logic [127:0] last_res, last_shuf;
    fork
      begin
        repeat (5000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none

    for (int i = 0; i < LANES; i++) opnd_b[i*LW +: LW] = 16'hA000 + 16'(i * 16'h0111);
    repeat (2) @(negedge clk);
    check("R1 reset out_valid", {127'b0, out_valid}, 128'd0);
    check("R1 reset res_q", res_q, '0);
    check("R1 reset shuf_q", shuf_q, '0);
    rst = 1'b0;
    @(negedge clk);

    // Shuffle: all 16 codes (R2 R3 R4 R5)
    for (int c = 0; c < 16; c++) begin
      elem_sel = 4'(c);
      strobe();
      for (int l = 0; l < LANES; l++) exp_v[l*LW +: LW] = opnd_b[src_of(c, l)*LW +: LW];
      check(c < 2 ? "R2 passthrough" : c < 4 ? "R3 pair dup" : c < 8 ? "R4 half bcast" : "R5 full bcast",
            shuf_q, exp_v);
      check("R10 out_valid after strobe", {127'b0, out_valid}, 128'd1);
    end

    // Clamp table, same accumulator in every lane (R6 R7 R8 R9)
    for (int r = 0; r < NROW; r++) begin
      for (int l = 0; l < LANES; l++) acc[l*AW +: AW] = CLAMP_TAB[r][ROW_W-1 -: AW];
      slice_mid = CLAMP_TAB[r][LW];
      strobe();
      exp_v = {LANES{CLAMP_TAB[r][LW-1:0]}};
      check($sformatf("R6-9 clamp row %0d", r), res_q, exp_v);
    end

    // R10: mixed lanes in one strobe, all written together
    clamp_neg = 16'hC001;
    clamp_pos = 16'h3FFE;
    slice_mid = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      acc[l*AW +: AW] = (l % 3 == 0) ? 48'h9000_0000_0000 :
                        (l % 3 == 1) ? 48'h0000_0000_1000 + 48'(l) : 48'h0002_0000_0000;
      exp_v[l*LW +: LW] = (l % 3 == 0) ? 16'hC001 : (l % 3 == 1) ? 16'h1000 + 16'(l) : 16'h3FFE;
    end
    strobe();
    check("R10 mixed lanes", res_q, exp_v);

    // R11: no strobe, inputs change, outputs hold
    last_res = res_q;
    last_shuf = shuf_q;
    acc = '1;
    elem_sel = 4'd9;
    clamp_neg = 16'h1234;
    @(negedge clk);
    @(negedge clk);
    check("R11 res hold", res_q, last_res);
    check("R11 shuf hold", shuf_q, last_shuf);
    check("R11 out_valid low", {127'b0, out_valid}, 128'd0);

    // R1: reset after activity
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset res_q", res_q, '0);
    check("R1 mid-run reset shuf_q", shuf_q, '0);
    rst = 1'b0;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule